// File: doc/BRIEF.md
# Recirculating Serial Output Port

This block turns a 64-bit parallel word into a stream of 4-bit nibbles. A word fetched from memory is first captured in a holding latch by a single-cycle load pulse. The latch is decoupled from the serial stream, so the memory side can refill it at any time. A separate read-transfer strobe picks the moment when the held word becomes the next serial block. This strobe arrives asynchronously, and its high-to-low transition copies the latch into a 16-slot ring of nibbles.

The ring presents one nibble per rising edge of the port clock. If no new transfer comes, it keeps cycling through the same 16 nibbles. An output enable models a tristate buffer. When the enable is low, the enable flag is low and the data lines are forced to zero. The ring keeps turning underneath while the output is disabled.

Top module: `serial_recirc_port`

## Requirements
- R1: While rst_ni is low and after its release, before any transfer, data_o is 0 and the ring holds an all-zero word.
- R2: At a rising clock edge where load_i is 1, the holding latch captures load_data_i. The latch keeps its value otherwise. A latch load alone never changes data_o.
- R3: The read-transfer strobe xfer_i passes through a two-flop synchroniser. If xfer_i is sampled low at edge k after being sampled high at edge k-1, the ring reloads from the latch at edge k+2. From then on, data_o shows nibble 0, which is bits [3:0] of the held word.
- R4: Each rising edge without a reload advances the output by one nibble. Nibble n is bits [4n+3:4n] of the transferred word.
- R5: After nibble 15 the output wraps to nibble 0 and repeats the same block for as long as no new transfer occurs.
- R6: A low-to-high transition of xfer_i, or xfer_i held high, causes no reload.
- R7: If a latch load and a ring reload fall on the same edge, the ring receives the latch value from before that edge. The new word stays in the latch for a later transfer.
- R8: When oe_i is 0, data_en_o is 0 and data_o is 0. The nibble position keeps advancing, so re-enabling resumes at the position the ring has reached by then.
- R9: Holding xfer_i low for many cycles causes exactly one reload.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port shift clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Single-cycle pulse that captures load_data_i into the holding latch |
| load_data_i | input | 64 | Parallel word read from memory |
| xfer_i | input | 1 | Asynchronous read-transfer strobe; its falling edge starts a new block |
| oe_i | input | 1 | Output enable, active high |
| data_o | output | 4 | Serial nibble output, zero when disabled |
| data_en_o | output | 1 | Output driver enable flag |

## Verification
A wrong ring position appears on data_o at the very next enabled clock as a nibble from the wrong bit slice of the word. A bad wrap shows up 16 cycles after a reload. A reload on the wrong edge moves the whole block by one or more cycles, so the first compare after the strobe exposes it. A latch that takes the new word too early, or fails to hold it, only becomes visible on the transfer that follows. For that reason the stimulus always follows a latch event with a reload and a full 16-nibble pass.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int unsigned SRP_NIB_W   = 4;
  localparam int unsigned SRP_DEPTH   = 16;
  localparam int unsigned SRP_SYNC_ST = 2;
endpackage

// File: rtl/srp_strobe_sync.sv
module srp_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic fall_o
);
  // stage STAGES is the edge-detect history flop
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-1:0], strobe_i};
  end

  assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];
endmodule

// File: rtl/srp_hold_latch.sv
module srp_hold_latch #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/srp_ring.sv
module srp_ring #(
  parameter int unsigned NIB_W = 4,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned WORD_W = NIB_W * DEPTH,
  localparam int unsigned IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reload_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [NIB_W-1:0]  nib_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [NIB_W-1:0] slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    localparam int unsigned NXT = (i + 1) % DEPTH;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       slot_q[i] <= '0;
      else if (reload_i) slot_q[i] <= word_i[i*NIB_W +: NIB_W];
      else               slot_q[i] <= slot_q[NXT];
    end
  end

  // block position, wraps naturally at DEPTH when DEPTH is a power of two
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       idx_o <= '0;
    else if (reload_i) idx_o <= '0;
    else if (idx_o == IDX_W'(DEPTH - 1)) idx_o <= '0;
    else               idx_o <= idx_o + 1'b1;
  end

  assign nib_o = slot_q[0];
endmodule

// File: rtl/serial_recirc_port.sv
module serial_recirc_port
  import srp_pkg::*;
#(
  parameter int unsigned NIB_W   = SRP_NIB_W,
  parameter int unsigned DEPTH   = SRP_DEPTH,
  parameter int unsigned SYNC_ST = SRP_SYNC_ST,
  localparam int unsigned WORD_W = NIB_W * DEPTH,
  localparam int unsigned IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_data_i,
  input  logic              xfer_i,
  input  logic              oe_i,
  output logic [NIB_W-1:0]  data_o,
  output logic              data_en_o
);
  logic              reload_pulse;
  logic [WORD_W-1:0] held_word;
  logic [NIB_W-1:0]  head_nib;
  logic [IDX_W-1:0]  blk_idx;

  srp_strobe_sync #(.STAGES(SYNC_ST)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(xfer_i),
    .fall_o  (reload_pulse)
  );

  srp_hold_latch #(.W(WORD_W)) u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (load_i),
    .d_i   (load_data_i),
    .q_o   (held_word)
  );

  // reload samples held_word before the same-edge latch update
  srp_ring #(.NIB_W(NIB_W), .DEPTH(DEPTH)) u_ring (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .reload_i(reload_pulse),
    .word_i  (held_word),
    .nib_o   (head_nib),
    .idx_o   (blk_idx)
  );

  assign data_en_o = oe_i;
  assign data_o    = oe_i ? head_nib : '0;
endmodule

// File: rtl/srp_checker.sv
module srp_checker #(
  parameter int unsigned NIB_W = 4,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned WORD_W = NIB_W * DEPTH,
  localparam int unsigned IDX_W  = $clog2(DEPTH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic [WORD_W-1:0] load_data_i,
  input logic [NIB_W-1:0]  data_o,
  input logic              data_en_o,
  input logic              reload_i,
  input logic [WORD_W-1:0] held_word,
  input logic [NIB_W-1:0]  head_nib,
  input logic [IDX_W-1:0]  blk_idx
);
  assert_disabled_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_en_o |-> data_o == '0);

  assert_latch_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> held_word == $past(load_data_i));

  assert_latch_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(held_word));

  assert_reload_old_word_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> head_nib == $past(held_word[NIB_W-1:0]));

  assert_reload_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> blk_idx == '0);

  assert_advance_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reload_i |=> blk_idx == IDX_W'(($past(blk_idx) + 1) % DEPTH));
endmodule

bind serial_recirc_port srp_checker #(.NIB_W(NIB_W), .DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_i     (load_i),
  .load_data_i(load_data_i),
  .data_o     (data_o),
  .data_en_o  (data_en_o),
  .reload_i   (reload_pulse),
  .held_word  (held_word),
  .head_nib   (head_nib),
  .blk_idx    (blk_idx)
);

// File: tb/serial_recirc_port_tb_top.sv
module serial_recirc_port_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0;
  logic [63:0] load_data_i = '0;
  logic        xfer_i = 1'b1;
  logic        oe_i = 1'b1;
  logic [3:0]  data_o;
  logic        data_en_o;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";
  bit cmp_on = 1'b0;

  always #2 clk_i = ~clk_i;

  serial_recirc_port dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .load_data_i(load_data_i),
    .xfer_i(xfer_i), .oe_i(oe_i), .data_o(data_o), .data_en_o(data_en_o)
  );

  // behavioural reference
  logic [63:0] m_latch, m_word;
  int m_idx;
  bit hist[$];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_latch = '0; m_word = '0; m_idx = 0;
      hist = '{1'b1, 1'b1, 1'b1};
    end else begin
      bit rl;
      rl = (hist[1] == 1'b0) && (hist[2] == 1'b1);
      if (rl) begin m_word = m_latch; m_idx = 0; end
      else m_idx = (m_idx + 1) % 16;
      if (load_i) m_latch = load_data_i;
      hist.push_front(xfer_i);
      void'(hist.pop_back());
    end
  end

  function automatic logic [3:0] exp_nib();
    return oe_i ? m_word[4*m_idx +: 4] : 4'h0;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    #1;
    if (cmp_on && rst_ni) begin
      check({cur_req, " data"}, {4'h0, data_o}, {4'h0, exp_nib()});
      check({cur_req, " en"}, {7'h0, data_en_o}, {7'h0, oe_i});
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic load_word(logic [63:0] w);
    load_i = 1'b1; load_data_i = w; cyc(1); load_i = 1'b0;
  endtask

  task automatic strobe();
    xfer_i = 1'b0; cyc(3); xfer_i = 1'b1;
  endtask

  localparam logic [63:0] W1 = 64'hFEDC_BA98_7654_3210;
  localparam logic [63:0] W2 = 64'h0F1E_2D3C_4B5A_6978;
  localparam logic [63:0] W3 = 64'hA5C3_9617_E2D4_B08F;
  localparam logic [63:0] W4 = 64'h1357_9BDF_0246_8ACE;

  initial begin
    #1;
    check("R1 reset data", {4'h0, data_o}, 8'h0);
    cyc(3);
    rst_ni = 1'b1;
    cmp_on = 1'b1;
    cyc(2);
    check("R1 post-reset data", {4'h0, data_o}, 8'h0);

    cur_req = "R2"; load_word(W1); cyc(3);
    check("R2 load alone no output change", {4'h0, data_o}, 8'h0);

    cur_req = "R3"; xfer_i = 1'b0; cyc(1);   // sampled low at edge k
    cyc(2);                                   // edges k+1, k+2
    check("R3 nibble0 after reload", {4'h0, data_o}, {4'h0, W1[3:0]});
    xfer_i = 1'b1;
    cur_req = "R4"; cyc(1);
    check("R4 nibble1", {4'h0, data_o}, {4'h0, W1[7:4]});
    cur_req = "R5"; cyc(15);
    check("R5 wrap to nibble0", {4'h0, data_o}, {4'h0, W1[3:0]});
    cyc(20);

    cur_req = "R6"; load_word(W2); cyc(5);
    xfer_i = 1'b0; xfer_i = 1'b1; cyc(20);
    check("R6 no reload on high", {4'h0, data_o}, {4'h0, exp_nib()});

    cur_req = "R9"; xfer_i = 1'b0; cyc(40); xfer_i = 1'b1; cyc(18);
    check("R9 single reload", {4'h0, data_o}, {4'h0, W2[4*m_idx +: 4]});

    cur_req = "R7"; load_word(W3); cyc(2);
    xfer_i = 1'b0; cyc(2);
    load_i = 1'b1; load_data_i = W4; cyc(1); load_i = 1'b0;
    check("R7 old latch transferred", {4'h0, data_o}, {4'h0, W3[3:0]});
    xfer_i = 1'b1; cyc(20);
    strobe(); cyc(1);
    check("R7 new word kept in latch", {4'h0, data_o}, {4'h0, W4[7:4]});
    cyc(10);

    cur_req = "R8"; oe_i = 1'b0; cyc(7);
    check("R8 disabled data", {4'h0, data_o}, 8'h0);
    check("R8 disabled en", {7'h0, data_en_o}, 8'h0);
    oe_i = 1'b1; cyc(1);
    check("R8 resume position", {4'h0, data_o}, {4'h0, W4[4*m_idx +: 4]});
    cyc(20);

    cur_req = "R4"; load_word(64'h0); strobe(); cyc(20);
    load_word(~W1); strobe(); cyc(40);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule